// File: doc/BRIEF.md
# Full-Cycle SPI Host Controller

This block is a byte-oriented SPI host that talks to a serial memory with a full SCK period of timing margin in both directions. It makes SCK from the system clock with an even divider that software sets per transfer, and it holds an active-low chip select across the whole transfer. Each transfer first sends a number of bytes (command, address and write data), MSB first, and then reads a number of bytes back.

Outgoing bits change on SCK rising edges. The device samples on the following rising edge, so every bit is stable for one full SCK period before it is sampled. The device launches each read bit on a falling edge, and the host captures that bit on the next falling edge, one full period later. Because of this delay the read phase runs one SCK cycle longer than its bit count. The host drops the sample from the first read-phase falling edge and takes the last read bit on the extra cycle.

The user side has a start pulse with a send count and a read count, a valid/ready byte handshake for outgoing bytes, a one-cycle valid pulse for each received byte, and a busy flag. When an outgoing byte is late, SCK stops low between bytes until the byte arrives.

Top module: `spi_fc_host`

## Requirements
- R1: After reset, and whenever no transfer is active, chip select is high, SCK is low, busy is low, the received-byte valid pulse is low and the host does not request outgoing bytes.
- R2: SCK idles low. While it runs, each high phase lasts exactly `half_div_i` system clocks and each low phase lasts at least that long, so an SCK period with no stall is 2·`half_div_i` clocks (`half_div_i` ≥ 1).
- R3: Outgoing bytes go out MSB first on the data-out pin. The first bit appears when chip select falls. While chip select stays low, the pin changes only on the clock in which SCK rises, so each bit is held one full period before the device samples it on a rising edge.
- R4: A bit the device launches on a falling edge is captured on the next falling edge. The sample from the first falling edge of the read phase is dropped. Read bytes are assembled MSB first, and each one is shown on `rx_data_o` with a `rx_valid_o` pulse exactly one clock long.
- R5: A transfer has exactly 8·`tx_len_i` SCK cycles, plus 8·`rx_len_i`+1 more when `rx_len_i` is not zero.
- R6: SCK is high only while chip select is low. The first rising edge comes at least `half_div_i` clocks after chip select falls. Chip select rises at least `half_div_i` clocks after the last falling edge, and only while SCK is low.
- R7: Busy rises in the clock after the start is accepted and stays high until chip select is released. A start pulse that arrives while busy is ignored and does not change the transfer in progress.
- R8: An outgoing byte is taken in a clock where both `tx_valid_i` and `tx_ready_o` are high, and only while SCK is low. If the next byte is not valid at a byte boundary, SCK stays low with chip select held, and no bit is lost.
- R9: Exactly `rx_len_i` received bytes are reported per transfer. A read count of zero gives a write-only transfer with no read phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| half_div_i | input | DIV_W | SCK half-period in system clocks, at least 1, taken at start |
| start_i | input | 1 | Start pulse, accepted when idle |
| tx_len_i | input | LEN_W | Number of bytes to send, at least 1, taken at start |
| rx_len_i | input | LEN_W | Number of bytes to read after the send phase, taken at start |
| busy_o | output | 1 | High from start until chip select is released |
| tx_data_i | input | BYTE_W | Outgoing byte |
| tx_valid_i | input | 1 | Outgoing byte is valid |
| tx_ready_o | output | 1 | Host takes the outgoing byte in this clock if it is valid |
| rx_data_o | output | BYTE_W | Last received byte |
| rx_valid_o | output | 1 | One-clock pulse for each received byte |
| spi_sck_o | output | 1 | Serial clock, idles low |
| spi_cs_n_o | output | 1 | Active-low chip select |
| spi_mosi_o | output | 1 | Serial data to the device |
| spi_miso_i | input | 1 | Serial data from the device |

## Verification
The assertions rely on the user never giving a send count or a half-period of zero, and on the device changing its data line only on SCK falling edges. With those inputs, captures in the host are at least two clocks apart. The stimulus draws send counts from 1 to 4, read counts from 0 to 5 and half-periods from 1 to 4. The device model in the bench drives only on falling edges and samples what the host held before each rising edge. Random gaps before outgoing bytes exercise the stall at byte boundaries, and a start pulse sent while busy checks that it is ignored.

// File: rtl/spi_fc_pkg.sv
// Shared types for the full-cycle SPI host.
// Assumes nothing beyond a single clock domain.
package spi_fc_pkg;

    // Sequencer states of the transfer engine
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,   // chip select high, waiting for start
        ST_LOAD = 3'd1,   // waiting for the first outgoing byte
        ST_LOW  = 3'd2,   // SCK low, next event is a rising edge
        ST_HIGH = 3'd3,   // SCK high, next event is a falling edge
        ST_HOLD = 3'd4    // SCK low after last falling edge, before release
    } fc_state_t;

endpackage

// File: rtl/spi_fc_clkgen.sv
// Half-period timer for SCK generation.
// The counter is reloaded on every SCK event (fire) and counts down to zero;
// "due" means the current half-period has elapsed. A stalled event keeps the
// counter at zero. Assumes reload_val = half period minus one.
module spi_fc_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic [DIV_W-1:0] reload_val,
    output logic             due
);

    logic [DIV_W-1:0] cnt_q;

    // Count the half-period down; restart on each SCK event
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (fire) begin
            cnt_q <= reload_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign due = (cnt_q == '0);

    // R2: after an event with a non-zero reload, the next event cannot be due at once
    p_no_early_edge_r2 : assert property (@(posedge clk) disable iff (!rst_n)
        (fire && reload_val != '0) |=> !due);

endmodule

// File: rtl/spi_fc_txshift.sv
// Outgoing shift register, MSB first.
// "load" places a new byte with its MSB on the output; "shift" advances one
// bit and fills with zeros. last_bit is high while the byte's LSB is on the
// pin. Assumes load and shift are never requested together.
module spi_fc_txshift #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic [BYTE_W-1:0] load_data,
    output logic              mosi,
    output logic              last_bit
);

    localparam int IDX_W = $clog2(BYTE_W);

    logic [BYTE_W-1:0] sr_q;
    logic [IDX_W-1:0]  idx_q;

    // Hold the byte on the line and advance on each rising-edge event
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q  <= '0;
            idx_q <= '0;
        end else if (load) begin
            sr_q  <= load_data;
            idx_q <= IDX_W'(BYTE_W - 1);
        end else if (shift) begin
            sr_q <= {sr_q[BYTE_W-2:0], 1'b0};
            if (idx_q != '0) begin
                idx_q <= idx_q - 1'b1;
            end
        end
    end

    assign mosi     = sr_q[BYTE_W-1];
    assign last_bit = (idx_q == '0);

    // R3: a new byte and a bit advance never collide
    p_load_shift_excl_r3 : assert property (@(posedge clk) disable iff (!rst_n)
        !(load && shift));

endmodule

// File: rtl/spi_fc_rxshift.sv
// Incoming shift register, MSB first.
// Each capture appends one bit; every BYTE_W captures the byte is registered
// and a one-clock valid pulse is raised. "clear" restarts the bit count.
// Assumes captures are at least two clocks apart.
module spi_fc_rxshift #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              capture,
    input  logic              sdi,
    output logic [BYTE_W-1:0] data,
    output logic              valid
);

    localparam int CNT_W = $clog2(BYTE_W);

    logic [BYTE_W-1:0] sr_q;
    logic [BYTE_W-1:0] data_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              valid_q;

    // Append captured bits and publish each completed byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q    <= '0;
            data_q  <= '0;
            cnt_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (clear) begin
                cnt_q <= '0;
            end else if (capture) begin
                sr_q <= {sr_q[BYTE_W-2:0], sdi};
                if (cnt_q == CNT_W'(BYTE_W - 1)) begin
                    cnt_q   <= '0;
                    data_q  <= {sr_q[BYTE_W-2:0], sdi};
                    valid_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign data  = data_q;
    assign valid = valid_q;

    // R4: each received byte is flagged for exactly one clock
    p_valid_pulse_r4 : assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

endmodule

// File: rtl/spi_fc_host.sv
// Full-cycle SPI host: sequencer and pin registers.
// Sends tx_len_i bytes MSB first, then reads rx_len_i bytes. Data out changes
// on SCK rising edges; read bits are captured on the falling edge one full
// period after the device launched them, so the read phase has one extra SCK
// cycle and drops its first falling-edge sample.
// Assumes half_div_i >= 1 and tx_len_i >= 1 when start_i is accepted.
module spi_fc_host
    import spi_fc_pkg::*;
#(
    parameter int DIV_W  = 8,
    parameter int LEN_W  = 8,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  half_div_i,
    input  logic              start_i,
    input  logic [LEN_W-1:0]  tx_len_i,
    input  logic [LEN_W-1:0]  rx_len_i,
    output logic              busy_o,
    input  logic [BYTE_W-1:0] tx_data_i,
    input  logic              tx_valid_i,
    output logic              tx_ready_o,
    output logic [BYTE_W-1:0] rx_data_o,
    output logic              rx_valid_o,
    output logic              spi_sck_o,
    output logic              spi_cs_n_o,
    output logic              spi_mosi_o,
    input  logic              spi_miso_i
);

    localparam int RDC_W = LEN_W + $clog2(BYTE_W) + 1;

    fc_state_t        state_q;
    logic [DIV_W-1:0] half_m1_q;
    logic [LEN_W-1:0] tx_left_q;
    logic [RDC_W-1:0] rd_cyc_q;
    logic             wr_done_q;
    logic             rd_phase_q;
    logic             rd_first_q;
    logic             sck_q;
    logic             cs_n_q;

    logic ck_due;
    logic ck_fire;
    logic tx_last;
    logic need_byte;
    logic take_byte;
    logic start_take;
    logic rise_ev;
    logic fall_ev;
    logic tx_shift;
    logic rx_cap;

    // Decode SCK events and the byte handshake from the current state
    always_comb begin
        start_take = (state_q == ST_IDLE) && start_i;
        need_byte  = (state_q == ST_LOW) && !wr_done_q && !rd_phase_q &&
                     tx_last && (tx_left_q != '0);
        tx_ready_o = (state_q == ST_LOAD) || (need_byte && ck_due);
        take_byte  = tx_ready_o && tx_valid_i;
        rise_ev    = (state_q == ST_LOW) && ck_due && (!need_byte || tx_valid_i);
        fall_ev    = (state_q == ST_HIGH) && ck_due;
        ck_fire    = rise_ev || fall_ev || ((state_q == ST_LOAD) && tx_valid_i);
        tx_shift   = rise_ev && !need_byte;
        rx_cap     = fall_ev && rd_phase_q && !rd_first_q;
    end

    spi_fc_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire       (ck_fire),
        .reload_val (half_m1_q),
        .due        (ck_due)
    );

    spi_fc_txshift #(.BYTE_W(BYTE_W)) u_txshift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (take_byte),
        .shift     (tx_shift),
        .load_data (tx_data_i),
        .mosi      (spi_mosi_o),
        .last_bit  (tx_last)
    );

    spi_fc_rxshift #(.BYTE_W(BYTE_W)) u_rxshift (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (start_take),
        .capture (rx_cap),
        .sdi     (spi_miso_i),
        .data    (rx_data_o),
        .valid   (rx_valid_o)
    );

    // Transfer sequencer: framing, SCK level and phase bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            half_m1_q  <= '0;
            tx_left_q  <= '0;
            rd_cyc_q   <= '0;
            wr_done_q  <= 1'b0;
            rd_phase_q <= 1'b0;
            rd_first_q <= 1'b0;
            sck_q      <= 1'b0;
            cs_n_q     <= 1'b1;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_take) begin
                        half_m1_q  <= half_div_i - 1'b1;
                        tx_left_q  <= tx_len_i - 1'b1;
                        rd_cyc_q   <= (rx_len_i == '0) ? '0 :
                                      RDC_W'(rx_len_i) * RDC_W'(BYTE_W) + RDC_W'(1);
                        wr_done_q  <= 1'b0;
                        rd_phase_q <= 1'b0;
                        rd_first_q <= 1'b0;
                        state_q    <= ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    if (tx_valid_i) begin
                        cs_n_q  <= 1'b0;
                        state_q <= ST_LOW;
                    end
                end
                ST_LOW: begin
                    if (rise_ev) begin
                        sck_q   <= 1'b1;
                        state_q <= ST_HIGH;
                        if (take_byte) begin
                            tx_left_q <= tx_left_q - 1'b1;
                        end
                        if (!rd_phase_q && !wr_done_q && tx_last && tx_left_q == '0) begin
                            wr_done_q <= 1'b1;
                        end
                    end
                end
                ST_HIGH: begin
                    if (fall_ev) begin
                        sck_q <= 1'b0;
                        if (rd_phase_q) begin
                            rd_first_q <= 1'b0;
                            rd_cyc_q   <= rd_cyc_q - 1'b1;
                            state_q    <= (rd_cyc_q == RDC_W'(1)) ? ST_HOLD : ST_LOW;
                        end else if (wr_done_q) begin
                            if (rd_cyc_q == '0) begin
                                state_q <= ST_HOLD;
                            end else begin
                                rd_phase_q <= 1'b1;
                                rd_first_q <= 1'b1;
                                state_q    <= ST_LOW;
                            end
                        end else begin
                            state_q <= ST_LOW;
                        end
                    end
                end
                ST_HOLD: begin
                    if (ck_due) begin
                        cs_n_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign spi_sck_o  = sck_q;
    assign spi_cs_n_o = cs_n_q;
    assign busy_o     = (state_q != ST_IDLE);

    // R6: SCK only pulses inside the chip-select frame
    p_sck_in_frame_r6 : assert property (@(posedge clk) disable iff (!rst_n)
        spi_sck_o |-> !spi_cs_n_o);

    // R6: release of chip select happens with SCK low
    p_release_low_r6 : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_cs_n_o) |-> !spi_sck_o);

    // R7: an active frame is always covered by busy
    p_frame_busy_r7 : assert property (@(posedge clk) disable iff (!rst_n)
        !spi_cs_n_o |-> busy_o);

    // R3: inside a frame the data line moves only with an SCK rise
    p_mosi_on_rise_r3 : assert property (@(posedge clk) disable iff (!rst_n)
        (!spi_cs_n_o && $past(!spi_cs_n_o) && !$rose(spi_sck_o)) |-> $stable(spi_mosi_o));

    // R8: outgoing bytes are taken only while SCK is low
    p_take_low_r8 : assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_i && tx_ready_o) |-> !spi_sck_o);

endmodule

// File: tb/spi_fc_host_tb.sv
// Self-checking bench with a memory-like device model that samples on SCK
// rising edges and drives on falling edges, returning a function of the bytes
// it received.
module spi_fc_host_tb_top;

    localparam int DIV_W  = 8;
    localparam int LEN_W  = 8;
    localparam int BYTE_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [DIV_W-1:0]  half_div = 8'd1;
    logic              start = 1'b0;
    logic [LEN_W-1:0]  tx_len = 8'd1;
    logic [LEN_W-1:0]  rx_len = 8'd0;
    logic              busy;
    logic [BYTE_W-1:0] tx_data = '0;
    logic              tx_valid = 1'b0;
    logic              tx_ready;
    logic [BYTE_W-1:0] rx_data;
    logic              rx_valid;
    logic              sck;
    logic              cs_n;
    logic              mosi;
    logic              miso = 1'b0;

    always #5 clk = ~clk;

    spi_fc_host #(.DIV_W(DIV_W), .LEN_W(LEN_W), .BYTE_W(BYTE_W)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .half_div_i (half_div),
        .start_i    (start),
        .tx_len_i   (tx_len),
        .rx_len_i   (rx_len),
        .busy_o     (busy),
        .tx_data_i  (tx_data),
        .tx_valid_i (tx_valid),
        .tx_ready_o (tx_ready),
        .rx_data_o  (rx_data),
        .rx_valid_o (rx_valid),
        .spi_sck_o  (sck),
        .spi_cs_n_o (cs_n),
        .spi_mosi_o (mosi),
        .spi_miso_i (miso)
    );

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    int xfer_id  = 0;
    int cur_ntx  = 1;
    int cur_half = 1;
    logic [7:0] tx_b [0:7];

    // Device model state
    logic       mosi_q = 1'b0;
    int         dev_id_a = 0;
    int         dev_id_b = 0;
    int         dev_rises = 0;
    int         dev_out_bits = 0;
    logic [7:0] dev_sr = '0;
    logic [7:0] dev_rx [0:7];

    // Expected read byte k: loopback of sent bytes with a twist
    function automatic logic [7:0] resp_of(logic [7:0] sent, int k);
        return sent ^ 8'h5A ^ 8'(k);
    endfunction

    function automatic int exp_rises(int ntx, int nrx);
        return 8 * ntx + ((nrx != 0) ? 8 * nrx + 1 : 0);
    endfunction

    // Hold the line value seen before the next clock edge
    always @(negedge clk) mosi_q = mosi;

    // Device samples on rising SCK
    always @(posedge sck) begin
        if (dev_id_a != xfer_id) begin
            dev_id_a  = xfer_id;
            dev_rises = 0;
        end
        if (!cs_n) begin
            dev_rises++;
            if (dev_rises <= 8 * cur_ntx) begin
                dev_sr = {dev_sr[6:0], mosi_q};
                if (dev_rises % 8 == 0) dev_rx[dev_rises / 8 - 1] = dev_sr;
            end
        end
    end

    // Device drives on falling SCK during the read phase
    always @(negedge sck) begin
        if (dev_id_b != xfer_id) begin
            dev_id_b     = xfer_id;
            dev_out_bits = 0;
        end
        if (cs_n === 1'b0 && dev_rises > 8 * cur_ntx) begin
            logic [7:0] rb;
            rb   = resp_of(dev_rx[(dev_out_bits / 8) % cur_ntx], dev_out_bits / 8);
            miso = rb[7 - (dev_out_bits % 8)];
            dev_out_bits++;
        end
    end

    // Pin monitor and received-byte collector
    int mon_id = 0;
    int rises, hi_run, lo_run, hi_bad, lo_bad, lead_bad, tail_bad, mosi_bad, rx_n;
    bit lead_pend;
    logic p_sck = 1'b0, p_cs = 1'b1, p_mosi = 1'b0;
    logic [7:0] rx_got [0:7];

    always @(negedge clk) begin
        if (mon_id != xfer_id) begin
            mon_id = xfer_id;
            rises = 0; hi_run = 0; lo_run = 0; hi_bad = 0; lo_bad = 0;
            lead_bad = 0; tail_bad = 0; mosi_bad = 0; rx_n = 0; lead_pend = 1'b0;
        end
        if (rst_n) begin
            if (!cs_n && p_cs) begin lo_run = 0; lead_pend = 1'b1; end
            if (!cs_n && !sck) lo_run++;
            if (sck) hi_run++;
            if (sck && !p_sck) begin
                rises++;
                if (lo_run < cur_half) begin
                    if (lead_pend) lead_bad++; else lo_bad++;
                end
                lead_pend = 1'b0;
                lo_run = 0;
            end
            if (!sck && p_sck) begin
                if (hi_run != cur_half) hi_bad++;
                hi_run = 0;
            end
            if (cs_n && !p_cs && lo_run < cur_half) tail_bad++;
            if (!cs_n && !p_cs && mosi !== p_mosi && !(sck && !p_sck)) mosi_bad++;
            if (rx_valid) begin
                if (rx_n < 8) rx_got[rx_n] = rx_data;
                rx_n++;
            end
        end
        p_sck = sck; p_cs = cs_n; p_mosi = mosi;
    end

    task automatic chk(bit ok, string req, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_xfer(int ntx, int nrx, int half, int gap_max, bit poke);
        int bad_tx = 0;
        int bad_rx = 0;
        bit busy_seen;
        for (int i = 0; i < 8; i++) tx_b[i] = 8'($urandom);
        cur_ntx  = ntx;
        cur_half = half;
        xfer_id++;
        @(negedge clk);
        @(negedge clk);
        half_div = DIV_W'(half);
        tx_len   = LEN_W'(ntx);
        rx_len   = LEN_W'(nrx);
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        busy_seen = busy;
        if (poke) begin
            tx_len = 8'd7; rx_len = 8'd7; half_div = 8'd9; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        for (int i = 0; i < ntx; i++) begin
            repeat ($urandom % (gap_max + 1)) @(negedge clk);
            tx_data  = tx_b[i];
            tx_valid = 1'b1;
            while (!tx_ready) @(negedge clk);
            @(negedge clk);
            tx_valid = 1'b0;
        end
        while (busy) @(negedge clk);
        @(negedge clk);
        chk(busy_seen, "R7 busy after start", int'(busy_seen), 1);
        for (int i = 0; i < ntx; i++) if (dev_rx[i] !== tx_b[i]) bad_tx++;
        chk(bad_tx == 0, (gap_max > 0) ? "R8 stalled bytes received by device"
                                       : "R3 bytes received by device", bad_tx, 0);
        chk(rx_n == nrx, "R9 received byte count", rx_n, nrx);
        for (int i = 0; i < nrx && i < rx_n; i++)
            if (rx_got[i] !== resp_of(tx_b[i % ntx], i)) bad_rx++;
        chk(bad_rx == 0, "R4 received byte values", bad_rx, 0);
        chk(rises == exp_rises(ntx, nrx), "R5 SCK cycle count", rises, exp_rises(ntx, nrx));
        chk(hi_bad == 0 && lo_bad == 0, "R2 SCK phase lengths", hi_bad + lo_bad, 0);
        chk(mosi_bad == 0, "R3 data line moves only on rise", mosi_bad, 0);
        chk(lead_bad == 0 && tail_bad == 0, "R6 select lead and tail", lead_bad + tail_bad, 0);
        if (poke) begin
            repeat (20) @(negedge clk);
            chk(!busy && cs_n, "R7 start while busy ignored", int'(busy), 0);
        end
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cs_n && !sck && !busy && !rx_valid && !tx_ready, "R1 reset state",
            {cs_n, sck, busy, rx_valid, tx_ready}, 5'b10000);
        // Directed corner cases
        run_xfer(1, 0, 1, 0, 1'b0);   // minimum divide, write only (R9)
        run_xfer(1, 1, 1, 0, 1'b0);   // single read byte with extra cycle (R4, R5)
        run_xfer(2, 3, 1, 0, 1'b0);
        run_xfer(4, 2, 3, 6, 1'b0);   // stalls at byte boundaries (R8)
        run_xfer(3, 0, 2, 20, 1'b0);  // long stalls, write only (R8)
        run_xfer(1, 2, 2, 0, 1'b1);   // start pulse while busy (R7)
        chk(cs_n && !sck && !busy && !tx_ready, "R1 idle between transfers",
            {cs_n, sck, busy, tx_ready}, 4'b1000);
        // Constrained random transfers
        for (int n = 0; n < 24; n++) begin
            run_xfer(1 + int'($urandom % 4), int'($urandom % 6), 1 + int'($urandom % 4),
                     int'($urandom % 13), 1'b0);
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule